// File: doc/BRIEF.md
# Pseudo-DMA Byte FIFO Bridge

This block connects a host CPU that moves data with programmed reads and writes to the byte-wide data port of a storage device. Data passes through a 16-byte staging FIFO in bursts. A data-request line (`dreq`) tells the host when it may move the next burst. A transfer counter holds the number of bytes still to move in the current transfer. The host port accepts 8-bit and 16-bit accesses. The FIFO level, the remaining count and a terminal-count flag are available to the host as registered status.

For a device-to-host transfer, the bridge first pulls min(remaining, 16) bytes from the device stream with `dreq` low. It then raises `dreq` and the terminal-count flag, and the host drains the FIFO. Once the FIFO is empty, the bridge either refills it or finishes with a one-cycle `dma_done` pulse. For a host-to-device transfer, `dreq` is high while the host writes bytes. When the counter reaches zero or the FIFO holds 16 bytes, `dreq` drops and the FIFO contents are streamed out to the device. After the flush, the host is asked for more data or the transfer completes. A `phase_end` input ends the transfer early at any point.

Top module: `pdma_fifo_bridge`

## Requirements
- R1: After synchronous reset, `dreq`, `tc_flag`, `dma_done`, `fifo_level`, `remaining` and `host_rdata` are all zero.
- R2: A start with `start_to_dev`=0 pulls exactly min(`xfer_len`,16) bytes from the device input. It then raises `dreq` and `tc_flag`, with `fifo_level` equal to that byte count and `remaining` reduced by it.
- R3: Host reads pop bytes in device order, and `host_rdata` is valid in the cycle after the read strobe. An 8-bit read returns the byte in bits 7:0 with bits 15:8 zero. A 16-bit read returns the first popped byte in bits 15:8 and the second in bits 7:0. When only one byte is held, bits 7:0 are zero.
- R4: When a host read empties the FIFO and `remaining` is nonzero, `dreq` and `tc_flag` fall in the next cycle and a refill of min(`remaining`,16) bytes follows.
- R5: When a host read empties the FIFO and `remaining` is zero, `dma_done` pulses for one cycle and `dreq` is low.
- R6: A start with `start_to_dev`=1 raises `dreq`. Each byte the host writes lowers `remaining` by one. A 16-bit write stores bits 15:8 first, then bits 7:0.
- R7: When `remaining` reaches zero or the FIFO holds 16 bytes, `dreq` falls and the held bytes leave on the device output in write order. After that, `dreq` rises again if `remaining` is nonzero; otherwise `dma_done` pulses.
- R8: A host read while `dreq` is low returns zero and leaves `fifo_level` and `remaining` unchanged.
- R9: `phase_end` lowers `dreq` and `tc_flag` and empties the FIFO by the next cycle, whatever the current state.
- R10: `fifo_level` always equals the number of bytes held, between 0 and 16.
- R11: A `start` while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (only taken when idle) |
| start_to_dev | input | 1 | Direction at start: 1 = host to device, 0 = device to host |
| xfer_len | input | 16 | Byte count loaded at start |
| phase_end | input | 1 | Early completion; drops `dreq` and empties the FIFO |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wide | input | 1 | Access is 16-bit when high |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered host read data |
| dreq | output | 1 | Data request to the host |
| tc_flag | output | 1 | FIFO loaded from device, transfer into FIFO complete |
| fifo_level | output | 5 | Bytes held in the FIFO |
| remaining | output | 16 | Transfer counter |
| dma_done | output | 1 | One-cycle completion pulse |
| dev_in_valid | input | 1 | Device byte available |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | Bridge accepts a device byte |
| dev_out_valid | output | 1 | Byte offered to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device accepts the offered byte |

## Verification
The assertions take for granted that the host moves data only while `dreq` is high. They also take for granted that `start` is pulsed with a length the host will then honour, and that the device handshakes follow valid/ready rules. The directed stimulus issues reads and writes only after waiting for `dreq`. It pulses the stray `start` and the empty-FIFO read only in states where the requirements define them as harmless. The device models keep `dev_in_valid` and `dev_out_ready` high, so bursts run back to back.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FILL    = 3'd1,
    ST_DRAIN   = 3'd2,
    ST_COLLECT = 3'd3,
    ST_FLUSH   = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/pdma_byte_store.sv
module pdma_byte_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we0,
  input  logic          we1,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata0,
  input  logic [7:0]    wdata1,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata0,
  output logic [7:0]    rdata1
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] waddr1;
  logic [AW-1:0] raddr1;

  assign waddr1 = waddr + AW'(1);
  assign raddr1 = raddr + AW'(1);

  always_ff @(posedge clk) begin
    if (we0) mem[waddr]  <= wdata0;
    if (we1) mem[waddr1] <= wdata1;
  end

  assign rdata0 = mem[raddr];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/pdma_host_rdfmt.sv
module pdma_host_rdfmt (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  logic        rd_fire,
  input  logic        rd_wide,
  input  logic        rd_two,
  input  logic [7:0]  byte0,
  input  logic [7:0]  byte1,
  output logic [15:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_req) begin
      if (!rd_fire)     rdata <= '0;
      else if (rd_wide) rdata <= {byte0, (rd_two ? byte1 : 8'h00)};
      else              rdata <= {8'h00, byte0};
    end
  end

  p_rd_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_fire) |=> (rdata == 16'h0000));
endmodule

// File: rtl/pdma_xfer_ctrl.sv
module pdma_xfer_ctrl
  import pdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_to_dev,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             phase_end,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             host_wide,
  input  logic             dev_in_valid,
  input  logic             dev_out_ready,
  output logic             dreq,
  output logic             tc_flag,
  output logic             dma_done,
  output logic [PW-1:0]    level,
  output logic [CNT_W-1:0] counter,
  output logic             dev_in_ready,
  output logic             dev_out_valid,
  output logic             rd_fire,
  output logic             rd_two,
  output logic             st_we0,
  output logic             st_we1,
  output logic             st_sel_dev,
  output logic [AW-1:0]    st_waddr,
  output logic [AW-1:0]    st_raddr
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  xfer_state_e   state;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [PW-1:0] burst;
  logic [PW-1:0] avail;
  logic [PW-1:0] pop_n;
  logic [PW-1:0] space;
  logic [PW-1:0] cnt_cap;
  logic [PW-1:0] room;
  logic [PW-1:0] wr_n;
  logic          wr_go;
  logic          fill_go;
  logic          flush_go;

  function automatic logic [PW-1:0] cap_len(input logic [CNT_W-1:0] n);
    return (n >= CNT_W'(DEPTH)) ? DEPTH_P : n[PW-1:0];
  endfunction

  assign avail   = wptr - rptr;
  assign level   = avail;
  assign space   = DEPTH_P - wptr;
  assign cnt_cap = cap_len(counter);
  assign room    = (space < cnt_cap) ? space : cnt_cap;

  assign rd_fire = host_rd && (state == ST_DRAIN) && (avail != '0);
  assign rd_two  = host_wide && (avail >= PW'(2));
  assign pop_n   = rd_two ? PW'(2) : PW'(1);

  assign wr_go = host_wr && (state == ST_COLLECT);
  always_comb begin
    if (!wr_go || room == '0)              wr_n = '0;
    else if (host_wide && room >= PW'(2))  wr_n = PW'(2);
    else                                   wr_n = PW'(1);
  end

  assign dev_in_ready  = (state == ST_FILL) && (wptr != burst);
  assign fill_go       = dev_in_valid && dev_in_ready;
  assign dev_out_valid = (state == ST_FLUSH) && (avail != '0);
  assign flush_go      = dev_out_valid && dev_out_ready;

  assign st_sel_dev = (state == ST_FILL);
  assign st_we0     = fill_go || (wr_n != '0);
  assign st_we1     = (wr_n == PW'(2));
  assign st_waddr   = wptr[AW-1:0];
  assign st_raddr   = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wptr     <= '0;
      rptr     <= '0;
      burst    <= '0;
      counter  <= '0;
      dreq     <= 1'b0;
      tc_flag  <= 1'b0;
      dma_done <= 1'b0;
    end else begin
      dma_done <= 1'b0;
      if (phase_end) begin
        state   <= ST_IDLE;
        wptr    <= '0;
        rptr    <= '0;
        dreq    <= 1'b0;
        tc_flag <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (start) begin
              counter <= xfer_len;
              wptr    <= '0;
              rptr    <= '0;
              tc_flag <= 1'b0;
              if (xfer_len == '0) begin
                dma_done <= 1'b1;
              end else if (start_to_dev) begin
                state <= ST_COLLECT;
                dreq  <= 1'b1;
              end else begin
                state <= ST_FILL;
                burst <= cap_len(xfer_len);
              end
            end
          end
          ST_FILL: begin
            if (fill_go) begin
              wptr    <= wptr + PW'(1);
              counter <= counter - CNT_W'(1);
              if (wptr + PW'(1) == burst) begin
                state   <= ST_DRAIN;
                dreq    <= 1'b1;
                tc_flag <= 1'b1;
              end
            end
          end
          ST_DRAIN: begin
            if (rd_fire) begin
              rptr <= rptr + pop_n;
              if (rptr + pop_n == wptr) begin
                wptr    <= '0;
                rptr    <= '0;
                dreq    <= 1'b0;
                tc_flag <= 1'b0;
                if (counter != '0) begin
                  state <= ST_FILL;
                  burst <= cnt_cap;
                end else begin
                  state    <= ST_IDLE;
                  dma_done <= 1'b1;
                end
              end
            end
          end
          ST_COLLECT: begin
            if (wr_n != '0) begin
              wptr    <= wptr + wr_n;
              counter <= counter - CNT_W'(wr_n);
              if ((counter == CNT_W'(wr_n)) || (wptr + wr_n == DEPTH_P)) begin
                state <= ST_FLUSH;
                dreq  <= 1'b0;
              end
            end
          end
          ST_FLUSH: begin
            if (flush_go) begin
              rptr <= rptr + PW'(1);
              if (rptr + PW'(1) == wptr) begin
                wptr <= '0;
                rptr <= '0;
                if (counter == '0) begin
                  state    <= ST_IDLE;
                  dma_done <= 1'b1;
                end else begin
                  state <= ST_COLLECT;
                  dreq  <= 1'b1;
                end
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: pointers keep the held count inside the FIFO
  p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
    (wptr >= rptr) && (wptr <= DEPTH_P));
  // R4: device fill never overlaps a host request
  p_fill_no_dreq_r4: assert property (@(posedge clk) disable iff (rst)
    dev_in_ready |-> !dreq);
  // R7: flush to device never overlaps a host request
  p_flush_no_dreq_r7: assert property (@(posedge clk) disable iff (rst)
    dev_out_valid |-> !dreq);
  // R5: completion pulse implies request is low
  p_done_no_dreq_r5: assert property (@(posedge clk) disable iff (rst)
    dma_done |-> !dreq);
  // R2: terminal-count flag only while the host is requested
  p_tc_with_dreq_r2: assert property (@(posedge clk) disable iff (rst)
    tc_flag |-> dreq);
  // R9: early completion empties and releases
  p_phase_end_r9: assert property (@(posedge clk) disable iff (rst)
    phase_end |=> (!dreq && level == '0));
  // R6: counter only falls during a transfer
  p_count_mono_r6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (counter <= $past(counter)));
endmodule

// File: rtl/pdma_fifo_bridge.sv
module pdma_fifo_bridge #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_to_dev,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             phase_end,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             host_wide,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  output logic             dreq,
  output logic             tc_flag,
  output logic [PW-1:0]    fifo_level,
  output logic [CNT_W-1:0] remaining,
  output logic             dma_done,
  input  logic             dev_in_valid,
  input  logic [7:0]       dev_in_data,
  output logic             dev_in_ready,
  output logic             dev_out_valid,
  output logic [7:0]       dev_out_data,
  input  logic             dev_out_ready
);
  logic          rd_fire;
  logic          rd_two;
  logic          st_we0;
  logic          st_we1;
  logic          st_sel_dev;
  logic [AW-1:0] st_waddr;
  logic [AW-1:0] st_raddr;
  logic [7:0]    wbyte0;
  logic [7:0]    byte0;
  logic [7:0]    byte1;

  assign wbyte0 = st_sel_dev ? dev_in_data :
                  (host_wide ? host_wdata[15:8] : host_wdata[7:0]);
  assign dev_out_data = byte0;

  pdma_xfer_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .start_to_dev  (start_to_dev),
    .xfer_len      (xfer_len),
    .phase_end     (phase_end),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_wide     (host_wide),
    .dev_in_valid  (dev_in_valid),
    .dev_out_ready (dev_out_ready),
    .dreq          (dreq),
    .tc_flag       (tc_flag),
    .dma_done      (dma_done),
    .level         (fifo_level),
    .counter       (remaining),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .rd_fire       (rd_fire),
    .rd_two        (rd_two),
    .st_we0        (st_we0),
    .st_we1        (st_we1),
    .st_sel_dev    (st_sel_dev),
    .st_waddr      (st_waddr),
    .st_raddr      (st_raddr)
  );

  pdma_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .we0    (st_we0),
    .we1    (st_we1),
    .waddr  (st_waddr),
    .wdata0 (wbyte0),
    .wdata1 (host_wdata[7:0]),
    .raddr  (st_raddr),
    .rdata0 (byte0),
    .rdata1 (byte1)
  );

  pdma_host_rdfmt u_rdfmt (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (host_rd),
    .rd_fire (rd_fire),
    .rd_wide (host_wide),
    .rd_two  (rd_two),
    .byte0   (byte0),
    .byte1   (byte1),
    .rdata   (host_rdata)
  );
endmodule

// File: tb/pdma_fifo_bridge_test.sv
module pdma_fifo_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, start_to_dev = 1'b0, phase_end = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        dreq, tc_flag, dma_done;
  logic [4:0]  fifo_level;
  logic [15:0] remaining;
  logic        dev_in_valid = 1'b1;
  logic [7:0]  dev_in_data;
  logic        dev_in_ready, dev_out_valid;
  logic [7:0]  dev_out_data;
  logic        dev_out_ready = 1'b1;

  int n_checks = 0, n_fail = 0;
  int cycles = 0, src_idx = 0, sink_n = 0, done_cnt = 0;
  logic [7:0] sink [64];

  always #4 clk = ~clk;

  pdma_fifo_bridge uut (
    .clk(clk), .rst(rst), .start(start), .start_to_dev(start_to_dev),
    .xfer_len(xfer_len), .phase_end(phase_end), .host_rd(host_rd),
    .host_wr(host_wr), .host_wide(host_wide), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dreq(dreq), .tc_flag(tc_flag),
    .fifo_level(fifo_level), .remaining(remaining), .dma_done(dma_done),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );

  assign dev_in_data = 8'h10 + src_idx[7:0];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
    if (dev_out_valid && dev_out_ready) begin
      sink[sink_n[5:0]] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
    if (dma_done) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_dreq(input string tag);
    int t = 0;
    while (!dreq && t < 300) begin @(negedge clk); t++; end
    chk({tag, " dreq rise"}, 32'(dreq), 32'd1);
  endtask

  task automatic do_start(input logic dir, input logic [15:0] len);
    @(negedge clk);
    start = 1'b1; start_to_dev = dir; xfer_len = len;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic hread(input logic wide);
    @(negedge clk);
    host_rd = 1'b1; host_wide = wide;
    @(negedge clk);
    host_rd = 1'b0; host_wide = 1'b0;
  endtask

  task automatic hwrite(input logic wide, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_wide = wide; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wide = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dreq", 32'(dreq), 0);
    chk("R1 tc", 32'(tc_flag), 0);
    chk("R1 level", 32'(fifo_level), 0);
    chk("R1 remaining", 32'(remaining), 0);
    chk("R1 rdata", 32'(host_rdata), 0);
    chk("R1 done", 32'(dma_done), 0);
  endtask

  task automatic t_dev_to_host;
    int base = src_idx;
    int d0 = done_cnt;
    do_start(1'b0, 16'd20);
    wait_dreq("R2");
    chk("R2 level", 32'(fifo_level), 16);
    chk("R2 tc", 32'(tc_flag), 1);
    chk("R2 remaining", 32'(remaining), 4);
    chk("R2 pulled", 32'(src_idx - base), 16);
    hread(1'b0);
    chk("R3 byte read", 32'(host_rdata), 32'(8'h10 + base));
    chk("R10 level after pop", 32'(fifo_level), 15);
    hread(1'b1);
    chk("R3 wide read", 32'(host_rdata), {16'h0, 8'(8'h11 + base), 8'(8'h12 + base)});
    for (int i = 3; i < 16; i++) hread(1'b0);
    chk("R3 last byte", 32'(host_rdata), 32'(8'h10 + base + 15));
    chk("R4 dreq drop", 32'(dreq), 0);
    chk("R4 tc drop", 32'(tc_flag), 0);
    wait_dreq("R4");
    chk("R4 refill level", 32'(fifo_level), 4);
    chk("R4 remaining", 32'(remaining), 0);
    hread(1'b1);
    chk("R3 wide refill", 32'(host_rdata), {16'h0, 8'(8'h10 + base + 16), 8'(8'h10 + base + 17)});
    hread(1'b1);
    chk("R5 dreq low", 32'(dreq), 0);
    chk("R5 done pulse", 32'(dma_done), 1);
    @(negedge clk);
    chk("R5 single pulse", 32'(dma_done), 0);
    chk("R5 done count", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_idle_read;
    int rem = remaining;
    hread(1'b1);
    chk("R8 idle read data", 32'(host_rdata), 0);
    chk("R8 level kept", 32'(fifo_level), 0);
    chk("R8 remaining kept", 32'(remaining), 32'(rem));
  endtask

  task automatic t_host_to_dev;
    int s0 = sink_n;
    int d0 = done_cnt;
    do_start(1'b1, 16'd18);
    chk("R6 dreq on start", 32'(dreq), 1);
    hwrite(1'b1, 16'hA0A1);
    chk("R6 remaining per byte", 32'(remaining), 16);
    for (int k = 1; k < 8; k++) hwrite(1'b1, {8'(8'hA0 + 2*k), 8'(8'hA1 + 2*k)});
    chk("R7 dreq drop on full", 32'(dreq), 0);
    wait_dreq("R7");
    chk("R7 flushed count", 32'(sink_n - s0), 16);
    for (int i = 0; i < 16; i++) chk("R7 flush order", 32'(sink[s0 + i]), 32'(8'hA0 + i));
    chk("R6 remaining after flush", 32'(remaining), 2);
    hwrite(1'b0, 16'h00B0);
    chk("R6 byte write count", 32'(remaining), 1);
    hwrite(1'b1, 16'hB1B2);
    chk("R7 dreq drop at zero", 32'(dreq), 0);
    repeat (6) @(negedge clk);
    chk("R7 done after flush", 32'(done_cnt - d0), 1);
    chk("R7 tail count", 32'(sink_n - s0), 18);
    chk("R7 tail byte0", 32'(sink[s0 + 16]), 32'h00B0);
    chk("R7 tail byte1 upper first", 32'(sink[s0 + 17]), 32'h00B1);
  endtask

  task automatic t_odd_wide;
    int base = src_idx;
    do_start(1'b0, 16'd3);
    wait_dreq("R2 short");
    chk("R2 short level", 32'(fifo_level), 3);
    hread(1'b1);
    chk("R3 wide pair", 32'(host_rdata), {16'h0, 8'(8'h10 + base), 8'(8'h11 + base)});
    hread(1'b1);
    chk("R3 wide single", 32'(host_rdata), {16'h0, 8'(8'h12 + base), 8'h00});
    chk("R5 short done", 32'(dma_done), 1);
  endtask

  task automatic t_busy_start_and_abort;
    do_start(1'b0, 16'd4);
    wait_dreq("R11");
    do_start(1'b1, 16'd99);
    chk("R11 remaining kept", 32'(remaining), 0);
    chk("R11 level kept", 32'(fifo_level), 4);
    chk("R11 dreq kept", 32'(dreq), 1);
    @(negedge clk);
    phase_end = 1'b1;
    @(negedge clk);
    phase_end = 1'b0;
    chk("R9 dreq low", 32'(dreq), 0);
    chk("R9 tc low", 32'(tc_flag), 0);
    chk("R9 level zero", 32'(fifo_level), 0);
    hread(1'b0);
    chk("R8 read after abort", 32'(host_rdata), 0);
  endtask

  initial begin
    t_reset();
    t_dev_to_host();
    t_idle_read();
    t_host_to_dev();
    t_odd_wide();
    t_busy_start_and_abort();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule